// File: doc/BRIEF.md
# Two-Stage Instruction Fetch Front End with Wrong-Path Squash

This block is the fetch half of a two-stage 32-bit core: stage one fetches, and stage two decodes, executes and writes back in one cycle. The block owns the program counter and presents it as the fetch address to an external instruction memory. That memory returns the addressed word in the same cycle. The block registers the word into the instruction register that feeds the execute stage. Alongside it, the block registers the address the word came from, so that the execute stage can compute relative targets and link values from its own instruction's address.

Software sees no delay slot. When the execute stage resolves a jump of any kind or a taken branch, it raises a redirect request and names the kind of target. The block then loads the new PC, which it computes from the executing instruction's address, its immediate fields or a register value supplied by the execute stage. In the same edge it loads the all-zero no-op into the instruction register in place of the word fetched down the wrong path. A not-taken branch raises no request, and the word after it executes normally.

Top module: `fetch_front`

## Requirements
- R1: While `rst` is high at a clock edge, the fetch address becomes 0x00000000, and both `ex_instr` and `ex_pc` become 0x00000000. The first instruction that executes after reset is therefore a no-op.
- R2: At an edge with `redirect_valid` low, the fetch address advances by 4.
- R3: At an edge with `redirect_valid` low, `ex_instr` takes the word on `fetch_word`, and `ex_pc` takes the fetch address that was presented during that cycle.
- R4: At an edge with `redirect_valid` high, `ex_instr` becomes 0x00000000 whatever word was fetched, and `ex_pc` still takes the fetch address of that cycle.
- R5: A redirect with `redirect_sel` = 2'b00 (branch) loads ex_pc + 4 + (sign-extended ex_instr[15:0] shifted left by 2) into the fetch address.
- R6: A redirect with `redirect_sel` = 2'b01 (absolute jump) loads {(ex_pc+4)[31:28], ex_instr[25:0], 2'b00} into the fetch address.
- R7: A redirect with `redirect_sel` = 2'b10 or 2'b11 (register jump) loads `reg_target` into the fetch address.
- R8: While `redirect_valid` is low, the values on `redirect_sel` and `reg_target` have no effect on the fetch address or on the instruction register.
- R9: One redirect squashes exactly one word. The word fetched from the target in the cycle after the redirect reaches `ex_instr` unsquashed, unless a further redirect arrives in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used ungated |
| rst | input | 1 | Synchronous reset, active high |
| fetch_addr | output | 32 | Address sent to instruction memory (the PC) |
| fetch_word | input | 32 | Instruction word at `fetch_addr` |
| redirect_valid | input | 1 | Execute stage resolved a jump or a taken branch |
| redirect_sel | input | 2 | Target kind: 00 branch, 01 absolute jump, 1x register |
| reg_target | input | 32 | Register value used as the target for register jumps |
| ex_instr | output | 32 | Instruction held for the execute stage |
| ex_pc | output | 32 | Address of the instruction in `ex_instr` |

## Verification
A redirect and a squash fall in the same edge. At that edge the PC takes the new target, and the word fetched down the wrong path must be replaced by a no-op instead of being shifted into execute. A scripted program provokes this with an absolute jump, a backward and a forward taken branch, a jump-and-link, and two register jumps. It also includes a not-taken branch whose successor must execute. A second phase drives redirects on arbitrary cycles, back-to-back redirects among them, with random target kinds and register values. A behavioural model predicts the PC, the instruction register and the execute PC for every cycle, and the bench compares them against the block on every clock.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
    localparam int XLEN = 32;

    typedef enum logic [1:0] {
        TGT_BRANCH = 2'b00,
        TGT_JABS   = 2'b01,
        TGT_JREG   = 2'b10,
        TGT_JREG2  = 2'b11
    } tgt_kind_e;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] ir;
        logic [XLEN-1:0] ex_pc;
    } fetch_state_t;
endpackage

// File: rtl/fetch_target_gen.sv
module fetch_target_gen
    import fetch_pkg::*;
#(
    parameter int W        = XLEN,
    parameter int IMM_W    = 16,
    parameter int JIDX_W   = 26,
    parameter int REGION_W = 4
) (
    input  logic [W-1:0]      ex_pc,
    input  logic [JIDX_W-1:0] ex_low,
    input  logic [1:0]        sel,
    input  logic [W-1:0]      reg_target,
    output logic [W-1:0]      target
);
    localparam int SHIFT = 2;
    localparam int EXT_W = W - IMM_W - SHIFT;

    logic [W-1:0] link;
    logic [W-1:0] br_off;
    logic [W-1:0] br_tgt;
    logic [W-1:0] jabs_tgt;

    always_comb begin
        link     = ex_pc + W'(4);
        br_off   = {{EXT_W{ex_low[IMM_W-1]}}, ex_low[IMM_W-1:0], {SHIFT{1'b0}}};
        br_tgt   = link + br_off;
        jabs_tgt = {link[W-1 -: REGION_W], ex_low, {SHIFT{1'b0}}};
        if (sel[1])
            target = reg_target;
        else if (sel[0])
            target = jabs_tgt;
        else
            target = br_tgt;
    end
endmodule

// File: rtl/fetch_kill_mux.sv
module fetch_kill_mux
    import fetch_pkg::*;
#(
    parameter int          W        = XLEN,
    parameter logic [W-1:0] NOP_WORD = '0
) (
    input  logic [W-1:0] fetched,
    input  logic         kill,
    output logic [W-1:0] to_exec
);
    always_comb begin
        to_exec = kill ? NOP_WORD : fetched;
    end
endmodule

// File: rtl/fetch_front.sv
module fetch_front
    import fetch_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] fetch_addr,
    input  logic [XLEN-1:0] fetch_word,
    input  logic            redirect_valid,
    input  logic [1:0]      redirect_sel,
    input  logic [XLEN-1:0] reg_target,
    output logic [XLEN-1:0] ex_instr,
    output logic [XLEN-1:0] ex_pc
);
    localparam int JIDX_W = 26;

    fetch_state_t st_d, st_q;
    logic [XLEN-1:0] redirect_tgt;
    logic [XLEN-1:0] word_in;

    fetch_target_gen #(.W(XLEN), .IMM_W(16), .JIDX_W(JIDX_W), .REGION_W(4)) u_tgt (
        .ex_pc      (st_q.ex_pc),
        .ex_low     (st_q.ir[JIDX_W-1:0]),
        .sel        (redirect_sel),
        .reg_target (reg_target),
        .target     (redirect_tgt)
    );

    fetch_kill_mux #(.W(XLEN), .NOP_WORD('0)) u_kill (
        .fetched (fetch_word),
        .kill    (redirect_valid),
        .to_exec (word_in)
    );

    always_comb begin
        st_d       = st_q;
        st_d.ir    = word_in;
        st_d.ex_pc = st_q.pc;
        st_d.pc    = redirect_valid ? redirect_tgt : st_q.pc + XLEN'(4);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.pc    <= RESET_PC;
            st_q.ir    <= '0;
            st_q.ex_pc <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_addr = st_q.pc;
    assign ex_instr   = st_q.ir;
    assign ex_pc      = st_q.ex_pc;
endmodule

// File: rtl/fetch_front_checker.sv
module fetch_front_checker (
    input logic        clk,
    input logic        rst,
    input logic [31:0] fetch_addr,
    input logic [31:0] fetch_word,
    input logic        redirect_valid,
    input logic [1:0]  redirect_sel,
    input logic [31:0] reg_target,
    input logic [31:0] ex_instr,
    input logic [31:0] ex_pc
);
    assert_seq_advance_R2: assert property (@(posedge clk) disable iff (rst)
        !redirect_valid |=> fetch_addr == $past(fetch_addr) + 32'd4);

    assert_word_forward_R3: assert property (@(posedge clk) disable iff (rst)
        !redirect_valid |=> (ex_instr == $past(fetch_word)) && (ex_pc == $past(fetch_addr)));

    assert_squash_nop_R4: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |=> ex_instr == 32'h0);

    assert_reg_jump_R7: assert property (@(posedge clk) disable iff (rst)
        (redirect_valid && redirect_sel[1]) |=> fetch_addr == $past(reg_target));
endmodule

bind fetch_front fetch_front_checker u_fetch_front_checker (
    .clk            (clk),
    .rst            (rst),
    .fetch_addr     (fetch_addr),
    .fetch_word     (fetch_word),
    .redirect_valid (redirect_valid),
    .redirect_sel   (redirect_sel),
    .reg_target     (reg_target),
    .ex_instr       (ex_instr),
    .ex_pc          (ex_pc)
);

// File: tb/fetch_front_bench.sv
`timescale 1ns/1ps
module fetch_front_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fetch_addr, fetch_word, reg_target, ex_instr, ex_pc;
    logic        redirect_valid = 1'b0;
    logic [1:0]  redirect_sel = 2'b00;

    logic [31:0] prog [64];
    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit phase2 = 1'b0;

    // reference model state
    logic [31:0] m_pc, m_ir, m_expc;
    bit   lr, l2, ign;
    logic [1:0] lsel;

    always #5 clk = ~clk;

    assign fetch_word = prog[fetch_addr[7:2]];

    fetch_front u_fetch_front (
        .clk(clk), .rst(rst), .fetch_addr(fetch_addr), .fetch_word(fetch_word),
        .redirect_valid(redirect_valid), .redirect_sel(redirect_sel),
        .reg_target(reg_target), .ex_instr(ex_instr), .ex_pc(ex_pc)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%08h expected=%08h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // behavioural model, updated at each edge from the inputs and its own state
    always @(posedge clk) begin
        logic [31:0] nxt, lk;
        if (rst) begin
            m_pc = 32'h0; m_ir = 32'h0; m_expc = 32'h0;
            lr = 0; l2 = 0; ign = 0; lsel = 2'b00;
        end else begin
            lk = m_expc + 4;
            if (!redirect_valid) nxt = m_pc + 4;
            else if (redirect_sel >= 2) nxt = reg_target;
            else if (redirect_sel == 1) nxt = {lk[31:28], m_ir[25:0], 2'b00};
            else nxt = lk + {{14{m_ir[15]}}, m_ir[15:0], 2'b00};
            l2 = lr;
            lr = redirect_valid;
            lsel = redirect_sel;
            ign = !redirect_valid && (redirect_sel != 2'b00);
            m_expc = m_pc;
            m_ir = redirect_valid ? 32'h0 : prog[m_pc[7:2]];
            m_pc = nxt;
        end
    end

    // compare, then drive the execute-stage decision for the next cycle
    always @(negedge clk) begin
        logic [5:0] op;
        logic [5:0] fn;
        if (rst) begin
            check("R1", "fetch_addr", fetch_addr, 32'h0);
            check("R1", "ex_instr", ex_instr, 32'h0);
            check("R1", "ex_pc", ex_pc, 32'h0);
        end else begin
            cycles++;
            check(lr ? (lsel == 0 ? "R5" : (lsel == 1 ? "R6" : "R7")) : (ign ? "R8" : "R2"),
                  "fetch_addr", fetch_addr, m_pc);
            check(lr ? "R4" : (l2 ? "R9" : (ign ? "R8" : "R3")), "ex_instr", ex_instr, m_ir);
            check("R3", "ex_pc", ex_pc, m_expc);
            if (!phase2) begin
                op = m_ir[31:26]; fn = m_ir[5:0];
                redirect_valid = 1'b0; redirect_sel = 2'b00;
                reg_target = {21'h0, m_ir[25:21], 6'h0};
                if (op == 6'd2 || op == 6'd3) begin redirect_valid = 1'b1; redirect_sel = 2'b01; end
                else if (op == 6'd0 && (fn == 6'd8 || fn == 6'd9)) begin redirect_valid = 1'b1; redirect_sel = 2'b10; end
                else if (op == 6'd4 && m_ir[25:21] == m_ir[20:16]) redirect_valid = 1'b1;
                else if (op == 6'd5 && m_ir[25:21] != m_ir[20:16]) redirect_valid = 1'b1;
            end else begin
                redirect_valid = ($urandom % 3) == 0;
                redirect_sel   = 2'($urandom);
                reg_target     = $urandom & 32'hFFFF_FFFC;
            end
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) prog[i] = 32'h2000_0000 | (i << 16) | i;
        prog[3]  = 32'h0800_000A; // absolute jump to word 10
        prog[12] = 32'h1000_0007; // taken branch forward to word 20
        prog[21] = 32'h1421_0000; // not-taken branch, word 22 executes
        prog[23] = 32'h0040_0008; // register jump to 0x80 (word 32)
        prog[32] = 32'h1000_FFF9; // taken branch backward to word 26
        prog[26] = 32'h0C00_002D; // jump-and-link to word 45
        prog[45] = 32'h0080_0009; // register jump-and-link to 0x100
        reg_target = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9 and the not-taken case: prove word 22 reaches execute after the branch at 21
        repeat (120) @(posedge clk);
        phase2 = 1'b1;
        repeat (600) @(posedge clk);
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 720);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule